// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit CPU bus with a 16-bit address and the external ROM and RAM of a cartridge. The CPU's lower 32 KiB window is ROM, but writes into that window do not reach the ROM. They load a small set of control registers instead: a RAM enable latch, a 5-bit lower ROM bank, a 2-bit upper field and a banking-mode bit. From these registers and the CPU address, the block forms a wide ROM address and a banked external RAM address. It drives the RAM write and select strobes and returns read data from whichever memory the address targets.

The lower 16 KiB of ROM space is pinned to bank 0. The upper 16 KiB shows a switchable bank. The lower bank register can never hold zero: a written value of zero is stored as one. The 2-bit upper field has two uses, chosen by the mode bit. In one mode it extends the ROM bank number. In the other it selects one of four 8 KiB RAM banks. RAM is reachable only after the enable key has been written.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, RAM is disabled, the lower bank register holds 1, the upper field is 0 and the mode is ROM banking. A read at 0x4000 therefore drives romAddr 0x004000, and a read at 0xA000 returns 0xFF with ramCe low.
- R2: For any CPU address 0x0000–0x3FFF, romAddr equals the address itself with every bank bit zero, and the read returns romData.
- R3: For any CPU address 0x4000–0x7FFF, romAddr is the active ROM bank times 0x4000 plus address bits 13:0, and the read returns romData. The active ROM bank is {upper field, lower bank} in ROM mode and {00, lower bank} in RAM mode.
- R4: A write of 0x0A to 0x0000–0x1FFF enables RAM. A write of 0x00 there disables it. Any other value written there leaves the enable unchanged.
- R5: A write to 0x2000–0x3FFF loads the lower bank register from data bits 4:0. Data bits 7:5 are ignored.
- R6: When data bits 4:0 of a lower-bank write are all zero, the register loads 1. A read in 0x4000–0x7FFF never drives ROM bank bits 4:0 to zero.
- R7: A write to 0x4000–0x5FFF loads the 2-bit upper field from data bits 1:0.
- R8: A write to 0x6000–0x7FFF sets the mode from data bit 0: 0 selects ROM banking, 1 selects RAM banking.
- R9: For CPU addresses 0xA000–0xBFFF, ramAddr is the RAM bank times 0x2000 plus address bits 12:0. The RAM bank is the upper field in RAM mode and 0 in ROM mode.
- R10: While RAM is enabled, an access to 0xA000–0xBFFF raises ramCe, a write there also raises ramWe with ramWrData equal to the CPU data, and a read returns ramData. While RAM is disabled, ramCe and ramWe stay low and reads there return 0xFF.
- R11: Accesses at 0x8000–0x9FFF and 0xC000–0xFFFF never raise ramCe or ramWe, change no register, and read back 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuWr | input | 1 | CPU write strobe, taken at the rising clock edge |
| cpuRd | input | 1 | CPU read strobe |
| cpuRdData | output | 8 | Read data returned to the CPU |
| romAddr | output | 21 | Physical ROM byte address |
| romData | input | 8 | ROM read data |
| ramAddr | output | 15 | Physical external RAM byte address |
| ramData | input | 8 | External RAM read data |
| ramWrData | output | 8 | External RAM write data |
| ramWe | output | 1 | External RAM write enable |
| ramCe | output | 1 | External RAM select |

## Verification
The state that is hardest to reach from the pins is a RAM bank above zero that stays reachable after the mode changes back. The data written in RAM mode must then stay hidden while bank 0 is served, and the ROM bank must lose its upper bits at the same time. The stimulus writes a nonzero upper field, switches to RAM mode, stores a marker byte, switches back and reads the same CPU address. It also writes zero and 0x20 to the lower bank while the upper field is nonzero, which exercises the substitution. A long pseudo-random phase then mixes enable keys, non-key values, bank writes and mode flips with ROM and RAM traffic. A behavioural model tracks every register and RAM byte and checks each cycle.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  // CPU bus address width; region decoding depends on its top bits
  localparam int unsigned CPU_AW = 16;

  typedef enum logic {
    MODE_ROM = 1'b0,
    MODE_RAM = 1'b1
  } bankMode_e;

  // Strobes from the region decoder to the datapath
  typedef struct packed {
    logic ramOnSet;   // enable key written
    logic ramOnClr;   // disable key written
    logic loBankLd;   // lower ROM bank load
    logic hiFieldLd;  // upper field load
    logic modeLd;     // banking mode load
    logic inRomLow;   // access in fixed ROM window
    logic inRomHigh;  // access in switchable ROM window
    logic ramAccess;  // read or write in RAM window
    logic ramWrite;   // write in RAM window
  } bankStrobe_t;

endpackage

// File: rtl/cart_bank_dec.sv
module cart_bank_dec
  import cart_bank_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] ENABLE_KEY  = 'h0A,
  parameter logic [DATA_W-1:0] DISABLE_KEY = 'h00
) (
  input  logic [2:0]        cpuRegion,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuWr,
  input  logic              cpuRd,
  output bankStrobe_t       strobe
);

  localparam logic [2:0] REG_ENABLE = 3'b000;
  localparam logic [2:0] REG_LOBANK = 3'b001;
  localparam logic [2:0] REG_HIFLD  = 3'b010;
  localparam logic [2:0] REG_MODE   = 3'b011;
  localparam logic [2:0] WIN_RAM    = 3'b101;

  logic inRam;

  assign inRam = (cpuRegion == WIN_RAM);

  always_comb begin
    strobe           = '0;
    strobe.inRomLow  = (cpuRegion[2:1] == 2'b00);
    strobe.inRomHigh = (cpuRegion[2:1] == 2'b01);
    strobe.ramAccess = inRam && (cpuRd || cpuWr);
    strobe.ramWrite  = inRam && cpuWr;
    if (cpuWr) begin
      unique case (cpuRegion)
        REG_ENABLE: begin
          strobe.ramOnSet = (cpuWrData == ENABLE_KEY);
          strobe.ramOnClr = (cpuWrData == DISABLE_KEY);
        end
        REG_LOBANK: strobe.loBankLd  = 1'b1;
        REG_HIFLD:  strobe.hiFieldLd = 1'b1;
        REG_MODE:   strobe.modeLd    = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cart_bank_path.sv
module cart_bank_path
  import cart_bank_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LO_BITS = 5,
  parameter int unsigned HI_BITS = 2,
  parameter int unsigned ROM_WIN = 14,
  parameter int unsigned RAM_WIN = 13,
  localparam int unsigned ROM_BANK_W = LO_BITS + HI_BITS,
  localparam int unsigned ROM_AW     = ROM_WIN + ROM_BANK_W,
  localparam int unsigned RAM_AW     = RAM_WIN + HI_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strobe,
  input  logic [ROM_WIN-1:0] cpuOffset,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] romData,
  input  logic [DATA_W-1:0] ramData,
  output logic [ROM_AW-1:0] romAddr,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWrData,
  output logic              ramWe,
  output logic              ramCe,
  output logic [DATA_W-1:0] cpuRdData
);

  logic              ramOn;
  logic [LO_BITS-1:0] loBank;
  logic [HI_BITS-1:0] hiField;
  bankMode_e          bankMode;

  logic [LO_BITS-1:0] loNext;
  logic [HI_BITS-1:0] romHi;
  logic [HI_BITS-1:0] ramBank;
  logic [ROM_BANK_W-1:0] romBank;

  // Zero is never stored: it would alias the fixed window
  assign loNext = (cpuWrData[LO_BITS-1:0] == '0) ? LO_BITS'(1) : cpuWrData[LO_BITS-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramOn    <= 1'b0;
      loBank   <= LO_BITS'(1);
      hiField  <= '0;
      bankMode <= MODE_ROM;
    end else begin
      if (strobe.ramOnSet)
        ramOn <= 1'b1;
      else if (strobe.ramOnClr)
        ramOn <= 1'b0;
      if (strobe.loBankLd)
        loBank <= loNext;
      if (strobe.hiFieldLd)
        hiField <= cpuWrData[HI_BITS-1:0];
      if (strobe.modeLd)
        bankMode <= bankMode_e'(cpuWrData[0]);
    end
  end

  // Upper field steered to ROM or RAM bank bits by the mode
  for (genvar g = 0; g < HI_BITS; g++) begin : g_steer
    assign romHi[g]   = hiField[g] & (bankMode == MODE_ROM);
    assign ramBank[g] = hiField[g] & (bankMode == MODE_RAM);
  end

  assign romBank = {romHi, loBank};

  always_comb begin
    if (strobe.inRomLow)
      romAddr = {{ROM_BANK_W{1'b0}}, cpuOffset};
    else
      romAddr = {romBank, cpuOffset};
  end

  assign ramAddr   = {ramBank, cpuOffset[RAM_WIN-1:0]};
  assign ramWrData = cpuWrData;
  assign ramCe     = strobe.ramAccess && ramOn;
  assign ramWe     = strobe.ramWrite && ramOn;

  always_comb begin
    if (strobe.inRomLow || strobe.inRomHigh)
      cpuRdData = romData;
    else if (strobe.ramAccess && ramOn)
      cpuRdData = ramData;
    else
      cpuRdData = '1;
  end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LO_BITS = 5,
  parameter int unsigned HI_BITS = 2,
  parameter int unsigned ROM_WIN = 14,
  parameter int unsigned RAM_WIN = 13,
  localparam int unsigned ROM_AW = ROM_WIN + LO_BITS + HI_BITS,
  localparam int unsigned RAM_AW = RAM_WIN + HI_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuWr,
  input  logic              cpuRd,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [ROM_AW-1:0] romAddr,
  input  logic [DATA_W-1:0] romData,
  output logic [RAM_AW-1:0] ramAddr,
  input  logic [DATA_W-1:0] ramData,
  output logic [DATA_W-1:0] ramWrData,
  output logic              ramWe,
  output logic              ramCe
);

  bankStrobe_t strobe;

  cart_bank_dec #(
    .DATA_W (DATA_W)
  ) u_dec (
    .cpuRegion (cpuAddr[CPU_AW-1:CPU_AW-3]),
    .cpuWrData (cpuWrData),
    .cpuWr     (cpuWr),
    .cpuRd     (cpuRd),
    .strobe    (strobe)
  );

  cart_bank_path #(
    .DATA_W  (DATA_W),
    .LO_BITS (LO_BITS),
    .HI_BITS (HI_BITS),
    .ROM_WIN (ROM_WIN),
    .RAM_WIN (RAM_WIN)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cpuOffset (cpuAddr[ROM_WIN-1:0]),
    .cpuWrData (cpuWrData),
    .romData   (romData),
    .ramData   (ramData),
    .romAddr   (romAddr),
    .ramAddr   (ramAddr),
    .ramWrData (ramWrData),
    .ramWe     (ramWe),
    .ramCe     (ramCe),
    .cpuRdData (cpuRdData)
  );

endmodule

// File: rtl/cart_bank_chk.sv
module cart_bank_chk
  import cart_bank_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ROM_WIN = 14,
  parameter int unsigned ROM_AW  = 21
) (
  input logic              clk,
  input logic              rstN,
  input logic [CPU_AW-1:0] cpuAddr,
  input logic [DATA_W-1:0] cpuWrData,
  input logic              cpuWr,
  input logic              cpuRd,
  input logic [DATA_W-1:0] cpuRdData,
  input logic [ROM_AW-1:0] romAddr,
  input logic              ramWe,
  input logic              ramCe
);

  logic inRam;
  logic inRomLow;
  logic inRomHigh;

  assign inRam     = (cpuAddr[CPU_AW-1:CPU_AW-3] == 3'b101);
  assign inRomLow  = (cpuAddr[CPU_AW-1:CPU_AW-2] == 2'b00);
  assign inRomHigh = (cpuAddr[CPU_AW-1:CPU_AW-2] == 2'b01);

  p_rom_low_fixed_r2: assert property (@(posedge clk) disable iff (!rstN)
    inRomLow |-> (romAddr[ROM_AW-1:ROM_WIN] == '0) &&
                 (romAddr[ROM_WIN-1:0] == cpuAddr[ROM_WIN-1:0]));

  p_bank_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    inRomHigh |-> (romAddr[ROM_AW-1:ROM_WIN] != '0));

  p_disable_blocks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr[CPU_AW-1:CPU_AW-3] == 3'b000 && cpuWrData == '0)
      |=> (!ramCe && !ramWe));

  p_off_reads_ff_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && inRam && !ramCe) |-> (cpuRdData == '1));

  p_we_needs_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (cpuWr && ramCe));

  p_outside_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !inRam |-> (!ramCe && !ramWe));

  p_outside_ff_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && cpuAddr[CPU_AW-1] && !inRam) |-> (cpuRdData == '1));

endmodule

bind cart_bank_ctrl cart_bank_chk #(
  .DATA_W  (DATA_W),
  .ROM_WIN (ROM_WIN),
  .ROM_AW  (ROM_AW)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuAddr   (cpuAddr),
  .cpuWrData (cpuWrData),
  .cpuWr     (cpuWr),
  .cpuRd     (cpuRd),
  .cpuRdData (cpuRdData),
  .romAddr   (romAddr),
  .ramWe     (ramWe),
  .ramCe     (ramCe)
);

// File: tb/sim_cart_bank_ctrl.sv
module sim_cart_bank_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ROM_AW = 21;
  localparam int RAM_AW = 15;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [15:0]       cpuAddr = '0;
  logic [7:0]        cpuWrData = '0;
  logic              cpuWr = 1'b0;
  logic              cpuRd = 1'b0;
  logic [7:0]        cpuRdData;
  logic [ROM_AW-1:0] romAddr;
  logic [7:0]        romData;
  logic [RAM_AW-1:0] ramAddr;
  logic [7:0]        ramData;
  logic [7:0]        ramWrData;
  logic              ramWe;
  logic              ramCe;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_ctrl u0 (
    .clk       (clk),
    .rstN      (rstN),
    .cpuAddr   (cpuAddr),
    .cpuWrData (cpuWrData),
    .cpuWr     (cpuWr),
    .cpuRd     (cpuRd),
    .cpuRdData (cpuRdData),
    .romAddr   (romAddr),
    .romData   (romData),
    .ramAddr   (ramAddr),
    .ramData   (ramData),
    .ramWrData (ramWrData),
    .ramWe     (ramWe),
    .ramCe     (ramCe)
  );

  // External memories
  function automatic logic [7:0] romFn(input int a);
    return 8'(a) ^ 8'(a >> 14) ^ 8'(a >> 9);
  endfunction

  function automatic logic [7:0] ramInit(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction

  logic [7:0] extRam [0:(1<<RAM_AW)-1];
  assign romData = romFn(int'(romAddr));
  assign ramData = extRam[ramAddr];
  always @(posedge clk) if (ramWe) extRam[ramAddr] <= ramWrData;

  // Reference model state
  int mEn, mLo, mHi, mMode;
  logic [7:0] refRam [int];

  function automatic logic [7:0] refRamRd(input int a);
    if (refRam.exists(a)) return refRam[a];
    return ramInit(a);
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int a, input int d, input bit wr, input bit rd, input string tag);
    int off, bank, eRom, eRam, eRd;
    bit inRam, eCe, eWe;
    @(negedge clk);
    cpuAddr = 16'(a); cpuWrData = 8'(d); cpuWr = wr; cpuRd = rd;
    #1;
    off   = a & 16'h3FFF;
    inRam = (a >= 16'hA000) && (a <= 16'hBFFF);
    bank  = (mMode == 1) ? mLo : ((mHi << 5) | mLo);
    eRom  = (a < 16'h4000) ? off : (bank * 16'h4000 + off);
    eRam  = ((mMode == 1) ? mHi : 0) * 16'h2000 + (a & 16'h1FFF);
    eCe   = inRam && (mEn != 0) && (rd || wr);
    eWe   = inRam && (mEn != 0) && wr;
    if (a < 16'h8000) eRd = romFn(eRom);
    else if (inRam && mEn != 0) eRd = refRamRd(eRam);
    else eRd = 8'hFF;
    if (a < 16'h8000) check(tag, "romAddr", int'(romAddr), eRom);
    if (inRam) check(tag, "ramAddr", int'(ramAddr), eRam);
    check(tag, "ramCe", int'(ramCe), int'(eCe));
    check(tag, "ramWe", int'(ramWe), int'(eWe));
    if (rd) check(tag, "cpuRdData", int'(cpuRdData), eRd);
    if (eWe) check(tag, "ramWrData", int'(ramWrData), d & 8'hFF);
    if (wr) begin
      if (a < 16'h2000) begin
        if ((d & 8'hFF) == 8'h0A) mEn = 1;
        else if ((d & 8'hFF) == 8'h00) mEn = 0;
      end else if (a < 16'h4000) begin
        mLo = d & 31;
        if (mLo == 0) mLo = 1;
      end else if (a < 16'h6000) mHi = d & 3;
      else if (a < 16'h8000) mMode = d & 1;
      else if (eWe) refRam[eRam] = 8'(d);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int unsigned lfsr;
    for (int i = 0; i < (1 << RAM_AW); i++) extRam[i] = ramInit(i);
    mEn = 0; mLo = 1; mHi = 0; mMode = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    step(16'h4000, 0, 0, 1, "R1");
    step(16'hA000, 0, 0, 1, "R1");
    step(16'hA000, 8'h11, 1, 0, "R1");
    // R2: fixed window
    step(16'h0000, 0, 0, 1, "R2");
    step(16'h3FFF, 0, 0, 1, "R2");
    step(16'h1234, 0, 0, 1, "R2");
    // R4 / R10: enable key, other value, disable key
    step(16'h0000, 8'h0A, 1, 0, "R4");
    step(16'hA000, 0, 0, 1, "R10");
    step(16'hA010, 8'h77, 1, 0, "R10");
    step(16'hA010, 0, 0, 1, "R10");
    step(16'h1FFF, 8'h05, 1, 0, "R4");
    step(16'hA010, 0, 0, 1, "R4");
    step(16'h1000, 8'h00, 1, 0, "R4");
    step(16'hA010, 0, 0, 1, "R4");
    step(16'hA011, 8'h99, 1, 0, "R10");
    step(16'h0100, 8'h0A, 1, 0, "R4");
    step(16'hA011, 0, 0, 1, "R10");
    // R5 / R6 / R7 / R3: bank registers
    step(16'h2000, 8'hE3, 1, 0, "R5");
    step(16'h4055, 0, 0, 1, "R5");
    step(16'h4000, 8'hFE, 1, 0, "R7");
    step(16'h4001, 0, 0, 1, "R7");
    step(16'h3FFF, 8'h00, 1, 0, "R6");
    step(16'h7FFF, 0, 0, 1, "R6");
    step(16'h2100, 8'h20, 1, 0, "R6");
    step(16'h5000, 0, 0, 1, "R6");
    step(16'h2000, 8'h1F, 1, 0, "R3");
    step(16'h7ABC, 0, 0, 1, "R3");
    // R8 / R9: mode switching with nonzero upper field
    step(16'h6000, 8'h01, 1, 0, "R8");
    step(16'h4000, 0, 0, 1, "R9");
    step(16'hBFFF, 0, 0, 1, "R9");
    step(16'hB000, 8'h33, 1, 0, "R9");
    step(16'hB000, 0, 0, 1, "R9");
    step(16'h6000, 8'h00, 1, 0, "R8");
    step(16'hB000, 0, 0, 1, "R9");
    step(16'h4000, 0, 0, 1, "R9");
    step(16'h7FFF, 8'h03, 1, 0, "R8");
    step(16'hB000, 0, 0, 1, "R8");
    step(16'h6000, 8'h02, 1, 0, "R8");
    step(16'h6123, 0, 0, 1, "R8");
    // R11: outside both windows
    step(16'h8000, 0, 0, 1, "R11");
    step(16'hC000, 0, 0, 1, "R11");
    step(16'hFFFF, 0, 0, 1, "R11");
    step(16'h9000, 8'h44, 1, 0, "R11");
    step(16'hE000, 8'h0A, 1, 0, "R11");
    step(16'h4000, 0, 0, 1, "R11");

    // Pseudo-random mix
    lfsr = 32'h1ACE5EED;
    for (int n = 0; n < 3000; n++) begin
      int kind, off, dat;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      kind = int'(lfsr & 7);
      off  = int'((lfsr >> 3) & 16'h1FFF);
      dat  = int'((lfsr >> 16) & 8'hFF);
      case (kind)
        0: step(off, ((lfsr >> 24) & 3) == 0 ? 8'h0A : (((lfsr >> 24) & 3) == 1 ? 8'h00 : dat), 1, 0, "R4");
        1: step(16'h2000 | off, ((lfsr >> 24) & 3) == 0 ? (dat & 8'hE0) : dat, 1, 0, "R5");
        2: step(16'h4000 | off, dat, 1, 0, "R7");
        3: step(16'h6000 | off, dat, 1, 0, "R8");
        4: step(off | ((lfsr >> 26) & 1) << 13, 0, 0, 1, "R2");
        5: step(16'h4000 | off | ((lfsr >> 26) & 1) << 13, 0, 0, 1, "R3");
        6: step(16'hA000 | off, dat, ((lfsr >> 27) & 1) == 1, ((lfsr >> 27) & 1) == 0, "R10");
        default: step(((lfsr >> 28) & 1) ? (16'hC000 | off | ((lfsr >> 29) & 1) << 13) : (16'h8000 | off),
                      dat, ((lfsr >> 30) & 1) == 1, ((lfsr >> 30) & 1) == 0, "R11");
      endcase
    end

    @(negedge clk);
    cpuWr = 1'b0; cpuRd = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule